// File: doc/BRIEF.md
# Quasi-Bidirectional General-Purpose Port Bank

This block provides three 8-bit general-purpose ports for a small controller core that reaches its peripherals through a special-function-register (SFR) bus. No pin has a direction register. Each pin has an output latch. A latch bit of 0 pulls the pad low. A latch bit of 1 releases the pad, so the pin can then act as an input. A released pin is either held high by a weak pull-up or left floating as an open-drain input, and a per-pin configuration bit chooses between the two.

The core reaches the ports in three ways:
- A byte write loads all eight latch bits of one port.
- A bit-addressed write changes a single latch bit and leaves the rest of the port alone.
- A read returns either the latch contents or the synchronized pin levels, chosen by a select input. The core uses the latch path for read-modify-write instructions and the pin path for plain reads.

A peripheral can take over any pin with a per-pin enable and value. While it does, the peripheral drives the pad and the latch is kept but not used.

Top module: `gpio_qb_port`

## Requirements
- R1: During and after a reset with `rst_n` low at a clock edge, every latch reads 0xFF, every pull-up configuration register reads 0x00, `pad_drive_low` is all zero and `pad_pullup_en` is all one.
- R2: A byte write (`sfr_wr`=1) to address 0x80, 0x90 or 0xA0 loads the latch of port 0, 1 or 2 respectively. From the next clock edge onward, with no override, `pad_drive_low` bit 8p+i equals the inverse of latch bit i of port p.
- R3: A bit write (`bit_wr`=1) with `bit_addr[7:3]` equal to the top five bits of a port's byte address sets latch bit `bit_addr[2:0]` of that port to `bit_val`. The port's other seven latch bits keep their values whatever their pins read.
- R4: A read with `sfr_rd_latch`=1 at a port address returns that port's latch contents, independent of `pad_in`.
- R5: A read with `sfr_rd_latch`=0 at a port address returns the pin levels through a two-flop synchronizer. A change of `pad_in` before clock edge k shows on `sfr_rdata` after edge k+1, and not after edge k.
- R6: Byte writes to 0xB2, 0xB3 and 0xB4 load the pull-up configuration of ports 0, 1 and 2. A configuration bit of 1 turns the weak pull-up off, so `pad_pullup_en` is its inverse. Reads of these addresses in either read mode return the register.
- R7: While `alt_en` bit n is 1, `pad_drive_low` bit n equals the inverse of `alt_out` bit n. The latch bit is kept and still returned by a read-latch access.
- R8: A bit write whose `bit_addr[7:3]` matches no port byte address changes no latch and no configuration register. This includes bit addresses 0xB0 to 0xB7.
- R9: A byte write to any address other than the six mapped ones changes no register. A read of an unmapped address returns 0x00.
- R10: When a byte write and a bit write hit the same port in the same cycle, the byte write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | 8 | SFR byte address for writes and reads |
| sfr_wdata | input | 8 | Byte write data |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_rd_latch | input | 1 | Read source: 1 = latch, 0 = synchronized pins |
| sfr_rdata | output | 8 | Read data for `sfr_addr` (combinational) |
| bit_wr | input | 1 | Bit write strobe |
| bit_addr | input | 8 | Bit address: upper five bits select the port, lower three the bit |
| bit_val | input | 1 | Value written by a bit write |
| alt_en | input | 24 | Per-pin peripheral override enable |
| alt_out | input | 24 | Per-pin peripheral output level |
| pad_in | input | 24 | Pin levels from the pads |
| pad_drive_low | output | 24 | Per-pin pull-down drive to the pads |
| pad_pullup_en | output | 24 | Per-pin weak pull-up enable to the pads |

## Verification
A corrupted latch bit shows up on `pad_drive_low` in the cycle after the write. It also shows up on a read-latch access of that port, with no further delay. A bit write that spills into a neighbouring bit changes a pad drive that should have stayed put, and that is visible one edge later. A synchronizer with the wrong depth makes a pin read show a new level one cycle early or late, so the bench samples on both sides of the expected edge. A register decode error shows as an unchanged pad vector or a wrong readback as soon as the affected address is read.

// File: rtl/gpio_qb_pkg.sv
// Package: shared sizes and the address map of the port bank.
// Assumes ports are 8 bits wide so bit addresses split as {byte[7:3], idx}.
package gpio_qb_pkg;
    localparam int NUM_PORTS = 3;
    localparam int PORT_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int BIT_IDX_W = $clog2(PORT_W);
    localparam int TOTAL_W   = NUM_PORTS * PORT_W;

    localparam logic [ADDR_W-1:0] DATA_BASE = 8'h80;
    localparam logic [ADDR_W-1:0] DATA_STEP = 8'h10;
    localparam logic [ADDR_W-1:0] PUP_BASE  = 8'hB2;

    // Byte address of port p's data latch.
    function automatic logic [ADDR_W-1:0] data_addr(input int p);
        return DATA_BASE + DATA_STEP * ADDR_W'(p);
    endfunction

    // Byte address of port p's pull-up configuration register.
    function automatic logic [ADDR_W-1:0] pup_addr(input int p);
        return PUP_BASE + ADDR_W'(p);
    endfunction
endpackage

// File: rtl/gpio_qb_sync.sv
// Module: two-stage synchronizer for a vector of pad inputs.
// Assumes each bit is independent; no bus coherence is implied.
module gpio_qb_sync #(
    parameter int W = 8,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Shift the raw level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= {W{RST_VAL}};
            q      <= {W{RST_VAL}};
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_qb_bank.sv
// Module: one quasi-bidirectional port: latch, pull-up config, pin sampling
// and pad drive with peripheral override.
// Assumes the caller decodes addresses; byte_wr takes precedence over bit_wr.
module gpio_qb_bank #(
    parameter int W = 8,
    localparam int IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_wr,
    input  logic [W-1:0]     wdata,
    input  logic             bit_wr,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    input  logic             pup_wr,
    input  logic [W-1:0]     alt_en,
    input  logic [W-1:0]     alt_out,
    input  logic [W-1:0]     pad_in,
    output logic [W-1:0]     latch_q,
    output logic [W-1:0]     pup_q,
    output logic [W-1:0]     pin_q,
    output logic [W-1:0]     pad_drive_low,
    output logic [W-1:0]     pad_pullup_en
);
    // Output latch: released (all ones) after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '1;
        end else if (byte_wr) begin
            latch_q <= wdata;
        end else if (bit_wr) begin
            latch_q[bit_idx] <= bit_val;
        end
    end

    // Pull-up configuration: 0 = pull-up on, reset to all on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pup_q <= '0;
        end else if (pup_wr) begin
            pup_q <= wdata;
        end
    end

    gpio_qb_sync #(.W(W), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_in),
        .q    (pin_q)
    );

    // Pad drive: peripheral value when overridden, else the latch.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            pad_drive_low[i] = alt_en[i] ? ~alt_out[i] : ~latch_q[i];
        end
        pad_pullup_en = ~pup_q;
    end
endmodule

// File: rtl/gpio_qb_port.sv
// Module: bank of quasi-bidirectional ports on an SFR bus.
// Decodes byte and bit writes, muxes the read path and drives the pads.
// Assumes reads are combinational and writes take effect at the next edge.
module gpio_qb_port
    import gpio_qb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    sfr_addr,
    input  logic [PORT_W-1:0]    sfr_wdata,
    input  logic                 sfr_wr,
    input  logic                 sfr_rd_latch,
    output logic [PORT_W-1:0]    sfr_rdata,
    input  logic                 bit_wr,
    input  logic [ADDR_W-1:0]    bit_addr,
    input  logic                 bit_val,
    input  logic [TOTAL_W-1:0]   alt_en,
    input  logic [TOTAL_W-1:0]   alt_out,
    input  logic [TOTAL_W-1:0]   pad_in,
    output logic [TOTAL_W-1:0]   pad_drive_low,
    output logic [TOTAL_W-1:0]   pad_pullup_en
);
    logic [PORT_W-1:0] latch_q [NUM_PORTS];
    logic [PORT_W-1:0] pup_q   [NUM_PORTS];
    logic [PORT_W-1:0] pin_q   [NUM_PORTS];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] D_ADDR = data_addr(p);
        localparam logic [ADDR_W-1:0] U_ADDR = pup_addr(p);
        logic byte_hit, bit_hit, pup_hit;

        // Address decode for this port.
        always_comb begin
            byte_hit = sfr_wr && (sfr_addr == D_ADDR);
            bit_hit  = bit_wr &&
                       (bit_addr[ADDR_W-1:BIT_IDX_W] == D_ADDR[ADDR_W-1:BIT_IDX_W]);
            pup_hit  = sfr_wr && (sfr_addr == U_ADDR);
        end

        gpio_qb_bank #(.W(PORT_W)) u_bank (
            .clk          (clk),
            .rst_n        (rst_n),
            .byte_wr      (byte_hit),
            .wdata        (sfr_wdata),
            .bit_wr       (bit_hit),
            .bit_idx      (bit_addr[BIT_IDX_W-1:0]),
            .bit_val      (bit_val),
            .pup_wr       (pup_hit),
            .alt_en       (alt_en[p*PORT_W +: PORT_W]),
            .alt_out      (alt_out[p*PORT_W +: PORT_W]),
            .pad_in       (pad_in[p*PORT_W +: PORT_W]),
            .latch_q      (latch_q[p]),
            .pup_q        (pup_q[p]),
            .pin_q        (pin_q[p]),
            .pad_drive_low(pad_drive_low[p*PORT_W +: PORT_W]),
            .pad_pullup_en(pad_pullup_en[p*PORT_W +: PORT_W])
        );
    end

    // Read path: latch or pins for data addresses, config regs, else zero.
    always_comb begin
        sfr_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (sfr_addr == data_addr(p)) begin
                sfr_rdata = sfr_rd_latch ? latch_q[p] : pin_q[p];
            end
            if (sfr_addr == pup_addr(p)) begin
                sfr_rdata = pup_q[p];
            end
        end
    end
endmodule

// File: rtl/gpio_qb_port_chk.sv
// Checker: temporal properties of the port bank, bound to the top module.
module gpio_qb_port_chk
    import gpio_qb_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    sfr_addr,
    input logic [PORT_W-1:0]    sfr_wdata,
    input logic                 sfr_wr,
    input logic                 sfr_rd_latch,
    input logic [PORT_W-1:0]    sfr_rdata,
    input logic                 bit_wr,
    input logic [ADDR_W-1:0]    bit_addr,
    input logic                 bit_val,
    input logic [TOTAL_W-1:0]   alt_en,
    input logic [TOTAL_W-1:0]   alt_out,
    input logic [TOTAL_W-1:0]   pad_in,
    input logic [TOTAL_W-1:0]   pad_drive_low,
    input logic [TOTAL_W-1:0]   pad_pullup_en
);
    // R1: first cycle out of reset, nothing driven low without override.
    p_reset_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && alt_en == '0) |-> pad_drive_low == '0);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        localparam logic [ADDR_W-1:0] D_ADDR = data_addr(p);

        // R2: byte write shows inverted on the pad drive next cycle.
        p_byte_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (sfr_wr && sfr_addr == D_ADDR) ##1 (alt_en[p*PORT_W +: PORT_W] == '0)
            |-> pad_drive_low[p*PORT_W +: PORT_W] == ~$past(sfr_wdata));

        // R3: bit write leaves the other seven pad drives untouched.
        p_bit_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (bit_wr && !sfr_wr && alt_en == '0 &&
             bit_addr[ADDR_W-1:BIT_IDX_W] == D_ADDR[ADDR_W-1:BIT_IDX_W])
            ##1 (alt_en == '0)
            |-> ((($past(pad_drive_low[p*PORT_W +: PORT_W]) ^
                   pad_drive_low[p*PORT_W +: PORT_W]) &
                  ~(PORT_W'(1) << $past(bit_addr[BIT_IDX_W-1:0]))) == '0));
    end

    // R5: pin reads of port 0 trail the pad by two edges.
    p_pin_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == data_addr(0) && !sfr_rd_latch && $past(rst_n) && $past(rst_n, 2))
        |-> sfr_rdata == $past(pad_in[PORT_W-1:0], 2));

    // R6, R8: pull-up enables move only on a config byte write.
    p_pup_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sfr_wr && sfr_addr >= pup_addr(0) && sfr_addr <= pup_addr(NUM_PORTS-1))
        |=> $stable(pad_pullup_en));

    // R7: an overridden pin follows the peripheral value.
    p_alt_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_drive_low ^ ~alt_out) & alt_en) == '0);
endmodule

bind gpio_qb_port gpio_qb_port_chk u_chk (.*);

// File: tb/gpio_qb_port_test.sv
module gpio_qb_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = '0;
    logic [7:0]  sfr_wdata = '0;
    logic        sfr_wr = 1'b0;
    logic        sfr_rd_latch = 1'b1;
    logic [7:0]  sfr_rdata;
    logic        bit_wr = 1'b0;
    logic [7:0]  bit_addr = '0;
    logic        bit_val = 1'b0;
    logic [23:0] alt_en = '0;
    logic [23:0] alt_out = '0;
    logic [23:0] pad_in = '1;
    logic [23:0] pad_drive_low;
    logic [23:0] pad_pullup_en;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Reference model state
    logic [7:0] m_latch [3];
    logic [7:0] m_pup [3];

    // Scoreboard: {kind[1:0], value[23:0]}; kind 0=rdata, 1=drive_low, 2=pullup_en
    logic [25:0] exp_q [$];
    string       tag_q [$];

    gpio_qb_port uut (.*);

    always #2 clk = ~clk;

    function automatic logic [23:0] model_drive();
        logic [23:0] v;
        for (int n = 0; n < 24; n++)
            v[n] = alt_en[n] ? ~alt_out[n] : ~m_latch[n/8][n%8];
        return v;
    endfunction

    function automatic logic [23:0] model_pullup();
        return ~{m_pup[2], m_pup[1], m_pup[0]};
    endfunction

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        for (int p = 0; p < 3; p++) begin
            if (a == 8'h80 + 8'(p * 16)) m_latch[p] = d;
            if (a == 8'hB2 + 8'(p)) m_pup[p] = d;
        end
        @(negedge clk); #1;
        sfr_wr = 1'b0;
    endtask

    task automatic wr_bit(input logic [7:0] a, input logic v);
        @(negedge clk); #1;
        bit_addr = a; bit_val = v; bit_wr = 1'b1;
        for (int p = 0; p < 3; p++)
            if (a[7:3] == 5'(((8'h80 + 8'(p * 16)) >> 3))) m_latch[p][a[2:0]] = v;
        @(negedge clk); #1;
        bit_wr = 1'b0;
    endtask

    // R10: both strobes to one port in one cycle
    task automatic wr_both(input logic [7:0] a, input logic [7:0] d, input logic [7:0] ba, input logic v);
        @(negedge clk); #1;
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        bit_addr = ba; bit_val = v; bit_wr = 1'b1;
        for (int p = 0; p < 3; p++)
            if (a == 8'h80 + 8'(p * 16)) m_latch[p] = d;
        @(negedge clk); #1;
        sfr_wr = 1'b0; bit_wr = 1'b0;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic lat, input logic [7:0] e, input string tag);
        @(negedge clk); #1;
        sfr_addr = a; sfr_rd_latch = lat;
        exp_q.push_back({2'd0, 16'h0, e});
        tag_q.push_back(tag);
    endtask

    task automatic chk_pads(input string tag);
        @(negedge clk); #1;
        exp_q.push_back({2'd1, model_drive()});
        tag_q.push_back(tag);
        exp_q.push_back({2'd2, model_pullup()});
        tag_q.push_back(tag);
    endtask

    task automatic chk_regs(input string tag);
        for (int p = 0; p < 3; p++) begin
            chk_rd(8'h80 + 8'(p * 16), 1'b1, m_latch[p], tag);
            chk_rd(8'hB2 + 8'(p), 1'b1, m_pup[p], tag);
        end
        chk_pads(tag);
    endtask

    // Monitor: pop and compare every queued item between edges
    initial begin
        forever begin
            @(negedge clk); #2;
            while (exp_q.size() > 0) begin
                logic [25:0] it;
                logic [23:0] act;
                string tg;
                it = exp_q.pop_front();
                tg = tag_q.pop_front();
                case (it[25:24])
                    2'd0:    act = {16'h0, sfr_rdata};
                    2'd1:    act = pad_drive_low;
                    default: act = pad_pullup_en;
                endcase
                total++;
                if (act !== it[23:0]) begin
                    bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", tg, it[25:24], act, it[23:0]);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < 3; p++) begin m_latch[p] = 8'hFF; m_pup[p] = 8'h00; end
        repeat (3) @(posedge clk);
        // R1: state held while reset is asserted
        chk_regs("R1 in reset");
        @(negedge clk); #1; rst_n = 1'b1;
        // R1: state right after reset
        chk_regs("R1 after reset");
        chk_rd(8'h80, 1'b0, 8'hFF, "R1 pin read");

        // R2: byte writes to each port
        wr_byte(8'h90, 8'h5A);
        chk_rd(8'h90, 1'b1, 8'h5A, "R2 latch p1");
        chk_pads("R2 pads p1");
        wr_byte(8'h80, 8'h00);
        wr_byte(8'hA0, 8'hC3);
        chk_regs("R2 all ports");

        // R3: bit writes, pins of port 1 forced low
        @(negedge clk); #1; pad_in = 24'hFF00FF;
        wr_bit(8'h90, 1'b1);
        wr_bit(8'h96, 1'b0);
        wr_bit(8'h97, 1'b1);
        chk_rd(8'h90, 1'b1, 8'h9B, "R3 bit writes p1");
        chk_pads("R3 pads");
        wr_bit(8'hA5, 1'b1);
        chk_regs("R3 port2 bit5");

        // R4: latch read ignores pins
        chk_rd(8'h90, 1'b1, 8'h9B, "R4 latch vs pins");

        // R5: synchronizer latency
        chk_rd(8'h90, 1'b0, 8'h00, "R5 pins low");
        @(negedge clk); #1; pad_in = 24'hFF5AFF;
        chk_rd(8'h90, 1'b0, 8'h00, "R5 not after one edge");
        chk_rd(8'h90, 1'b0, 8'h5A, "R5 after two edges");
        chk_rd(8'hA0, 1'b0, 8'hFF, "R5 port2 pins");

        // R6: pull-up configuration
        wr_byte(8'hB3, 8'hF0);
        wr_byte(8'hB4, 8'h81);
        chk_rd(8'hB3, 1'b0, 8'hF0, "R6 readback pin mode");
        chk_regs("R6 config");

        // R7: peripheral override
        @(negedge clk); #1; alt_en = 24'h010001; alt_out = 24'h000001;
        chk_pads("R7 override");
        chk_rd(8'hA0, 1'b1, m_latch[2], "R7 latch kept");
        @(negedge clk); #1; alt_out = 24'h010000;
        chk_pads("R7 override flip");
        @(negedge clk); #1; alt_en = '0; alt_out = '0;
        chk_pads("R7 release");

        // R8: bit writes to non-port bit addresses
        wr_bit(8'hB3, 1'b1);
        wr_bit(8'hB0, 1'b1);
        wr_bit(8'h88, 1'b1);
        chk_regs("R8 ignored bit writes");

        // R9: unmapped byte write and read
        wr_byte(8'h81, 8'h77);
        wr_byte(8'hB5, 8'h77);
        chk_regs("R9 ignored byte writes");
        chk_rd(8'h81, 1'b1, 8'h00, "R9 unmapped read");
        chk_rd(8'hB5, 1'b0, 8'h00, "R9 unmapped read pin mode");

        // R10: byte write beats bit write
        wr_both(8'h80, 8'h3C, 8'h80, 1'b1);
        chk_rd(8'h80, 1'b1, 8'h3C, "R10 precedence");
        chk_pads("R10 pads");

        // R1: reset again restores defaults
        @(negedge clk); #1; rst_n = 1'b0;
        for (int p = 0; p < 3; p++) begin m_latch[p] = 8'hFF; m_pup[p] = 8'h00; end
        @(negedge clk); #1; rst_n = 1'b1;
        chk_regs("R1 re-reset");

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule